// File: doc/BRIEF.md
# J1850 In-Frame-Response Transmit Sequencer

This block runs the transmit side of an in-frame response (IFR) on a J1850 byte data link. Software arms a response with a request strobe that picks between two kinds: a multi-byte response closed by a CRC byte, or a single-byte response that is retried after losing arbitration. Software feeds bytes through a one-byte data register and may request end-of-data at any point. The block moves bytes into its transmit shifter and raises a transmit-empty flag, with an optional interrupt, each time the data register is drained. It then closes the response with a CRC byte and an end-of-data symbol, or with a forced-ones symbol when the response is cut short.

Bit timing and the receive path belong to a separate symbol layer. That layer reports bus events as single-cycle pulses: end of the main frame, another node's normalization bit, a received byte, arbitration loss (and whether it fell on the last bit), a reception error, and a successful IFR from another node. The block hands that layer one symbol at a time over a valid/ready port.

The symbol port follows these back-pressure rules. `sym_valid` stays high, with `sym_kind`, `sym_data` and `sym_norm` unchanged, until the cycle in which `sym_ready` is high. No new symbol is offered until `sym_done` reports that the accepted one has finished on the bus, or until an arbitration loss or reception error ends it.

Top module: `ifr_tx_seq`

## Requirements
- R1: A request strobe taken while idle sets `ifr_pending`. Transmission starts on the first `ev_eod_rx` or `ev_norm_bit` pulse seen while a request is pending and the data register holds a byte. With no such pulse, nothing is offered. The first symbol is kind 0 (data), carries the data register byte, and has `sym_norm`=1.
- R2: `tdre` goes to 1 in the cycle after a byte moves from the data register into the shifter, and a CPU write clears it. `irq` equals `tdre` AND `cpu_irq_en`. Both are 0 after reset.
- R3: In a multi-byte response, each byte written before the current one finishes is sent next as kind 0 with `sym_norm`=0. When a data byte finishes with the register empty and end-of-data requested, a kind-1 symbol follows, then a kind-2 symbol. The kind-1 symbol carries the inverse of a CRC-8 (polynomial 0x1D, start value 0xFF, most significant bit first) taken over all data bytes of the response. `ifr_pending` clears when the kind-2 symbol finishes.
- R4: If end-of-data is requested before a multi-byte response starts, the response is exactly one data byte, then the CRC symbol, then end-of-data.
- R5: `ev_other_ifr_ok` or `ev_rx_err` clears a pending request while idle. `ev_rx_err` also aborts any transmission in progress and returns to idle with `ifr_pending`=0.
- R6: When a multi-byte data byte finishes with the register empty and no end-of-data requested (underrun), a kind-3 (forced-ones) symbol is offered. `inv_sym_err` is set and `ifr_pending` is cleared.
- R7: An arbitration loss during a multi-byte response sets `arb_lost`, clears `ifr_pending` and makes no retry. If the loss fell on the last bit, a kind-3 symbol is offered; otherwise nothing more is sent. A new request strobe clears `arb_lost` and `inv_sym_err`.
- R8: An arbitration loss during a single-byte response without end-of-data sends nothing extra, even on the last bit, and keeps the request pending. The same byte is offered again with `sym_norm`=0 after the next `ev_rx_byte`. An end-of-data request or reception error while waiting cancels the retry.
- R9: A single-byte response that succeeds sends its data symbol, then a kind-2 symbol, with no CRC. If end-of-data was requested before it started, one arbitration loss ends it with `ifr_pending`=0.
- R10: While `sym_valid` is high and `sym_ready` low, `sym_valid`, `sym_kind` and `sym_data` hold their values.
- R11: A CPU write in the same cycle as `sym_done` of a multi-byte data byte counts as a refill. The written byte is sent next, with no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_wdata | input | 8 | Data register write value |
| cpu_req_stb | input | 1 | Request an IFR (taken while idle) |
| cpu_req_multi | input | 1 | Kind with the strobe: 1 multi-byte with CRC, 0 single byte |
| cpu_eod_set | input | 1 | Request end-of-data |
| cpu_irq_en | input | 1 | Interrupt enable |
| ev_eod_rx | input | 1 | End of main frame received |
| ev_norm_bit | input | 1 | Another node's normalization bit seen |
| ev_rx_byte | input | 1 | A received byte completed on the bus |
| ev_arb_lost | input | 1 | Arbitration lost on the current symbol |
| ev_arb_last_bit | input | 1 | With ev_arb_lost: loss fell on the last bit |
| ev_rx_err | input | 1 | Reception error |
| ev_other_ifr_ok | input | 1 | Another node finished an IFR successfully |
| sym_valid | output | 1 | Symbol offered to the symbol layer |
| sym_ready | input | 1 | Symbol layer accepts the offer |
| sym_kind | output | 2 | 0 data, 1 CRC, 2 end-of-data, 3 forced ones |
| sym_data | output | 8 | Byte for data and CRC symbols |
| sym_norm | output | 1 | Send a normalization bit before this byte |
| sym_done | input | 1 | Accepted symbol finished on the bus |
| tdre | output | 1 | Transmit data register empty flag |
| irq | output | 1 | Interrupt request |
| ifr_pending | output | 1 | An IFR request is pending or in progress |
| arb_lost | output | 1 | Arbitration-loss flag |
| inv_sym_err | output | 1 | Invalid-symbol error after underrun |

## Verification
The CPU refill write and the end of the byte in the shifter can fall in the same cycle. That cycle decides between a refill and an underrun. The bench provokes it by raising `cpu_wr`, `sym_done` and `cpu_eod_set` on one clock edge. It judges the result by three observations: the next symbol must be a data symbol carrying the fresh byte, `inv_sym_err` must stay low, and the following CRC must cover both bytes. The same stall holds `sym_ready` low for several cycles to confirm that the offer stays stable under back-pressure.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_CRC  = 2'd1,
    SYM_EOD  = 2'd2,
    SYM_ONES = 2'd3
  } sym_kind_t;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_OFFER   = 2'd1,
    S_BUSY    = 2'd2,
    S_WAITWIN = 2'd3
  } seq_st_t;
endpackage

// File: rtl/ifr_crc8.sv
module ifr_crc8 #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 'h1D,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] acc_q, base, nxt;

  always_comb begin
    base = restart ? INIT : acc_q;
    nxt  = base ^ din;
    for (int i = 0; i < W; i++) begin
      nxt = nxt[W-1] ? ((nxt << 1) ^ POLY) : (nxt << 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              acc_q <= INIT;
    else if (restart || upd) acc_q <= nxt;
  end

  assign crc_out = ~acc_q;
endmodule

// File: rtl/ifr_data_reg.sv
module ifr_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  input  logic         irq_en,
  output logic [W-1:0] byte_out,
  output logic         avail,
  output logic         tdre,
  output logic         irq
);
  logic [W-1:0] hold_q;
  logic         full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      tdre   <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
      tdre   <= 1'b1;
    end else if (wr) begin
      hold_q <= wdata;
      full_q <= 1'b1;
      tdre   <= 1'b0;
    end
  end

  assign avail    = full_q | wr;
  assign byte_out = wr ? wdata : hold_q;
  assign irq      = tdre & irq_en;

  AST_TDRE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tdre); // R2
  AST_TAKE_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (full_q || wr)); // R11
endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_req_stb,
  input  logic         cpu_req_multi,
  input  logic         cpu_eod_set,
  input  logic         ev_eod_rx,
  input  logic         ev_norm_bit,
  input  logic         ev_rx_byte,
  input  logic         ev_arb_lost,
  input  logic         ev_arb_last_bit,
  input  logic         ev_rx_err,
  input  logic         ev_other_ifr_ok,
  input  logic         sym_ready,
  input  logic         sym_done,
  input  logic [W-1:0] dr_byte,
  input  logic         dr_avail,
  input  logic [W-1:0] crc_val,
  output logic         take,
  output logic         crc_restart,
  output logic         sym_valid,
  output sym_kind_t    sym_kind,
  output logic [W-1:0] sym_data,
  output logic         sym_norm,
  output logic         ifr_pending,
  output logic         arb_lost,
  output logic         inv_sym_err
);
  seq_st_t      st;
  sym_kind_t    kind_q;
  logic [W-1:0] shf_q;
  logic         norm_q, req_q, multi_q, eod_q, arb_q, inv_q;
  logic         start, arb_hit, data_done, refill;

  always_comb begin
    start     = (st == S_IDLE) && req_q && dr_avail && (ev_eod_rx || ev_norm_bit)
                && !ev_rx_err && !ev_other_ifr_ok;
    arb_hit   = (st == S_BUSY) && ev_arb_lost && !ev_rx_err
                && (kind_q == SYM_DATA || kind_q == SYM_CRC);
    data_done = (st == S_BUSY) && sym_done && !ev_rx_err && !arb_hit && (kind_q == SYM_DATA);
    refill    = data_done && multi_q && dr_avail;
    take        = start || refill;
    crc_restart = start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind_q <= SYM_DATA; shf_q <= '0; norm_q <= 1'b0;
      req_q <= 1'b0; multi_q <= 1'b0; eod_q <= 1'b0; arb_q <= 1'b0; inv_q <= 1'b0;
    end else begin
      if (cpu_req_stb && st == S_IDLE) begin
        req_q <= 1'b1; multi_q <= cpu_req_multi; eod_q <= 1'b0;
        arb_q <= 1'b0; inv_q <= 1'b0;
      end
      if (cpu_eod_set) eod_q <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (ev_other_ifr_ok || ev_rx_err) req_q <= 1'b0;
          else if (start) begin
            shf_q <= dr_byte; kind_q <= SYM_DATA; norm_q <= 1'b1; st <= S_OFFER;
          end
        end
        S_OFFER: begin
          if (ev_rx_err) begin req_q <= 1'b0; st <= S_IDLE; end
          else if (sym_ready) st <= S_BUSY;
        end
        S_BUSY: begin
          if (ev_rx_err) begin req_q <= 1'b0; st <= S_IDLE; end
          else if (arb_hit) begin
            arb_q <= 1'b1;
            if (multi_q) begin
              req_q <= 1'b0;
              if (ev_arb_last_bit) begin
                kind_q <= SYM_ONES; norm_q <= 1'b0; st <= S_OFFER;
              end else st <= S_IDLE;
            end else if (eod_q) begin
              req_q <= 1'b0; st <= S_IDLE;
            end else st <= S_WAITWIN;
          end else if (sym_done) begin
            norm_q <= 1'b0;
            unique case (kind_q)
              SYM_DATA: begin
                st <= S_OFFER;
                if (!multi_q)      kind_q <= SYM_EOD;
                else if (dr_avail) shf_q  <= dr_byte;
                else if (eod_q) begin
                  kind_q <= SYM_CRC; shf_q <= crc_val;
                end else begin
                  kind_q <= SYM_ONES; inv_q <= 1'b1; req_q <= 1'b0;
                end
              end
              SYM_CRC: begin kind_q <= SYM_EOD; st <= S_OFFER; end
              SYM_EOD: begin req_q <= 1'b0; st <= S_IDLE; end
              SYM_ONES: st <= S_IDLE;
            endcase
          end
        end
        S_WAITWIN: begin
          if (ev_rx_err || cpu_eod_set) begin req_q <= 1'b0; st <= S_IDLE; end
          else if (ev_rx_byte) begin norm_q <= 1'b0; st <= S_OFFER; end
        end
      endcase
    end
  end

  assign sym_valid   = (st == S_OFFER);
  assign sym_kind    = kind_q;
  assign sym_data    = shf_q;
  assign sym_norm    = norm_q;
  assign ifr_pending = req_q;
  assign arb_lost    = arb_q;
  assign inv_sym_err = inv_q;

  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready && !ev_rx_err) |=> (sym_valid && $stable(sym_data) && $stable(sym_kind))); // R10
  AST_RETRY_NO_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITWIN && ev_rx_byte && !ev_rx_err && !cpu_eod_set)
      |=> (sym_valid && !sym_norm && sym_kind == SYM_DATA)); // R8
  AST_MULTI_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_hit && multi_q) |=> (!ifr_pending && arb_lost && st != S_WAITWIN)); // R7
  AST_ONES_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_kind == SYM_ONES) |-> !ifr_pending); // R6
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_err && st != S_IDLE) |=> (st == S_IDLE && !ifr_pending)); // R5
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq
  import ifr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] CRC_POLY = 'h1D,
  parameter logic [W-1:0] CRC_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  input  logic         cpu_req_stb,
  input  logic         cpu_req_multi,
  input  logic         cpu_eod_set,
  input  logic         cpu_irq_en,
  input  logic         ev_eod_rx,
  input  logic         ev_norm_bit,
  input  logic         ev_rx_byte,
  input  logic         ev_arb_lost,
  input  logic         ev_arb_last_bit,
  input  logic         ev_rx_err,
  input  logic         ev_other_ifr_ok,
  output logic         sym_valid,
  input  logic         sym_ready,
  output logic [1:0]   sym_kind,
  output logic [W-1:0] sym_data,
  output logic         sym_norm,
  input  logic         sym_done,
  output logic         tdre,
  output logic         irq,
  output logic         ifr_pending,
  output logic         arb_lost,
  output logic         inv_sym_err
);
  logic [W-1:0] dr_byte, crc_val;
  logic         dr_avail, take, crc_restart;
  sym_kind_t    kind_w;

  ifr_data_reg #(.W(W)) u_dr (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata), .take(take),
    .irq_en(cpu_irq_en), .byte_out(dr_byte), .avail(dr_avail), .tdre(tdre), .irq(irq)
  );

  ifr_crc8 #(.W(W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .restart(crc_restart), .upd(take),
    .din(dr_byte), .crc_out(crc_val)
  );

  ifr_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req_stb(cpu_req_stb), .cpu_req_multi(cpu_req_multi),
    .cpu_eod_set(cpu_eod_set), .ev_eod_rx(ev_eod_rx), .ev_norm_bit(ev_norm_bit),
    .ev_rx_byte(ev_rx_byte), .ev_arb_lost(ev_arb_lost), .ev_arb_last_bit(ev_arb_last_bit),
    .ev_rx_err(ev_rx_err), .ev_other_ifr_ok(ev_other_ifr_ok), .sym_ready(sym_ready),
    .sym_done(sym_done), .dr_byte(dr_byte), .dr_avail(dr_avail), .crc_val(crc_val),
    .take(take), .crc_restart(crc_restart), .sym_valid(sym_valid), .sym_kind(kind_w),
    .sym_data(sym_data), .sym_norm(sym_norm), .ifr_pending(ifr_pending),
    .arb_lost(arb_lost), .inv_sym_err(inv_sym_err)
  );

  assign sym_kind = kind_w;
endmodule

// File: tb/ifr_tx_seq_test.sv
module ifr_tx_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cpu_wr, cpu_req_stb, cpu_req_multi, cpu_eod_set, cpu_irq_en;
  logic [7:0] cpu_wdata, sym_data;
  logic ev_eod_rx, ev_norm_bit, ev_rx_byte, ev_arb_lost, ev_arb_last_bit, ev_rx_err, ev_other_ifr_ok;
  logic sym_valid, sym_ready, sym_norm, sym_done;
  logic [1:0] sym_kind;
  logic tdre, irq, ifr_pending, arb_lost, inv_sym_err;

  ifr_tx_seq uut (.*);

  int n_run = 0, n_fail = 0;

  // Stimulus vectors: {byte count, b0, b1, b2}; expected symbols are n data, CRC, EOD.
  localparam logic [31:0] VEC [4] = '{32'h01_5A_00_00, 32'h02_12_34_00,
                                      32'h03_A5_5A_FF, 32'h03_01_02_03};

  localparam int P_EODRX = 0, P_NORM = 1, P_RXB = 2, P_ARB = 3, P_ARBLAST = 4,
                 P_RXERR = 5, P_OTHER = 6, P_DONE = 7, P_EODSET = 8;

  function automatic logic [7:0] crc_ref(input logic [7:0] b [3], input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ b[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return ~c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int p);
    case (p)
      P_EODRX:   ev_eod_rx = 1'b1;
      P_NORM:    ev_norm_bit = 1'b1;
      P_RXB:     ev_rx_byte = 1'b1;
      P_ARB:     ev_arb_lost = 1'b1;
      P_ARBLAST: begin ev_arb_lost = 1'b1; ev_arb_last_bit = 1'b1; end
      P_RXERR:   ev_rx_err = 1'b1;
      P_OTHER:   ev_other_ifr_ok = 1'b1;
      P_DONE:    sym_done = 1'b1;
      default:   cpu_eod_set = 1'b1;
    endcase
    @(negedge clk);
    {ev_eod_rx, ev_norm_bit, ev_rx_byte, ev_arb_lost, ev_arb_last_bit} = '0;
    {ev_rx_err, ev_other_ifr_ok, sym_done, cpu_eod_set} = '0;
  endtask

  task automatic req(input logic multi);
    cpu_req_multi = multi; cpu_req_stb = 1'b1;
    @(negedge clk);
    cpu_req_stb = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    cpu_wdata = b; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic serve(input string tag, input logic [1:0] ek, input logic [7:0] ed, input logic en);
    bit ok = 0;
    for (int i = 0; i < 40; i++) begin
      if (sym_valid) begin ok = 1; break; end
      @(negedge clk);
    end
    chk({tag, " offer"}, {31'd0, ok}, 32'd1);
    if (ok) begin
      chk({tag, " kind"}, {30'd0, sym_kind}, {30'd0, ek});
      if (ek < 2) chk({tag, " data"}, {24'd0, sym_data}, {24'd0, ed});
      if (ek == 0) chk({tag, " norm"}, {31'd0, sym_norm}, {31'd0, en});
      sym_ready = 1'b1;
      @(negedge clk);
      sym_ready = 1'b0;
    end
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, {31'd0, sym_valid}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b [3];
    int n;
    rst_n = 0; cpu_wr = 0; cpu_wdata = 0; cpu_req_stb = 0; cpu_req_multi = 0;
    cpu_eod_set = 0; cpu_irq_en = 0; sym_ready = 0; sym_done = 0;
    {ev_eod_rx, ev_norm_bit, ev_rx_byte, ev_arb_lost, ev_arb_last_bit, ev_rx_err, ev_other_ifr_ok} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state (R2)
    chk("R2 reset tdre", {31'd0, tdre}, 0);
    chk("R2 reset irq", {31'd0, irq}, 0);
    chk("R1 reset valid", {31'd0, sym_valid}, 0);
    chk("R1 reset pending", {31'd0, ifr_pending}, 0);
    chk("R7 reset arb", {31'd0, arb_lost}, 0);
    chk("R6 reset inv", {31'd0, inv_sym_err}, 0);

    // Vector walk: multi-byte responses (R1 R2 R3 R4)
    for (int v = 0; v < 4; v++) begin
      n = int'(VEC[v][31:24]);
      b[0] = VEC[v][23:16]; b[1] = VEC[v][15:8]; b[2] = VEC[v][7:0];
      cpu_irq_en = v[0];
      req(1'b1);
      wr(b[0]);
      if (n == 1) pulse(P_EODSET);
      pulse(P_EODRX);
      chk("R2 tdre after load", {31'd0, tdre}, 1);
      chk("R2 irq follows enable", {31'd0, irq}, {31'd0, v[0]});
      serve("R1 first byte", 2'd0, b[0], 1'b1);
      for (int i = 1; i < n; i++) begin
        wr(b[i]);
        chk("R2 tdre cleared by write", {31'd0, tdre}, 0);
        if (i == n - 1) pulse(P_EODSET);
        pulse(P_DONE);
        serve("R3 next byte", 2'd0, b[i], 1'b0);
      end
      pulse(P_DONE);
      serve(n == 1 ? "R4 crc" : "R3 crc", 2'd1, crc_ref(b, n), 1'b0);
      pulse(P_DONE);
      serve("R3 eod", 2'd2, 8'h00, 1'b0);
      pulse(P_DONE);
      chk("R3 pending cleared", {31'd0, ifr_pending}, 0);
    end
    cpu_irq_en = 0;

    // R11 + R10: refill write in the same cycle as done, with a stalled offer
    req(1'b1);
    wr(8'h3C);
    pulse(P_EODRX);
    serve("R11 first", 2'd0, 8'h3C, 1'b1);
    cpu_wr = 1; cpu_wdata = 8'hC3; sym_done = 1; cpu_eod_set = 1;
    @(negedge clk);
    cpu_wr = 0; sym_done = 0; cpu_eod_set = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R10 valid held", {31'd0, sym_valid}, 1);
      chk("R10 data held", {24'd0, sym_data}, 32'hC3);
      @(negedge clk);
    end
    serve("R11 refill byte", 2'd0, 8'hC3, 1'b0);
    chk("R11 no underrun", {31'd0, inv_sym_err}, 0);
    pulse(P_DONE);
    b[0] = 8'h3C; b[1] = 8'hC3;
    serve("R11 crc", 2'd1, crc_ref(b, 2), 1'b0);
    pulse(P_DONE);
    serve("R11 eod", 2'd2, 8'h00, 1'b0);
    pulse(P_DONE);

    // R6 underrun
    req(1'b1);
    wr(8'h44);
    pulse(P_EODRX);
    serve("R6 byte", 2'd0, 8'h44, 1'b1);
    pulse(P_DONE);
    serve("R6 ones", 2'd3, 8'h00, 1'b0);
    chk("R6 inv set", {31'd0, inv_sym_err}, 1);
    chk("R6 pending cleared", {31'd0, ifr_pending}, 0);
    pulse(P_DONE);
    quiet("R6 idle", 3);

    // R7 multi arbitration loss, not last bit then last bit
    req(1'b1);
    chk("R7 flags cleared by request", {30'd0, arb_lost, inv_sym_err}, 0);
    wr(8'h11);
    pulse(P_EODRX);
    serve("R7 byte", 2'd0, 8'h11, 1'b1);
    pulse(P_ARB);
    chk("R7 arb flag", {31'd0, arb_lost}, 1);
    chk("R7 pending cleared", {31'd0, ifr_pending}, 0);
    quiet("R7 no extra", 2);
    pulse(P_RXB);
    quiet("R7 no retry", 3);
    req(1'b1);
    wr(8'h22);
    pulse(P_EODRX);
    serve("R7 byte2", 2'd0, 8'h22, 1'b1);
    pulse(P_ARBLAST);
    serve("R7 last-bit ones", 2'd3, 8'h00, 1'b0);
    pulse(P_DONE);
    quiet("R7 idle", 2);

    // R8 single-byte retry and R9 success
    req(1'b0);
    wr(8'h77);
    pulse(P_EODRX);
    serve("R8 first", 2'd0, 8'h77, 1'b1);
    pulse(P_ARBLAST);
    quiet("R8 no extra bits", 3);
    chk("R8 still pending", {31'd0, ifr_pending}, 1);
    chk("R8 arb flag", {31'd0, arb_lost}, 1);
    pulse(P_RXB);
    serve("R8 retry", 2'd0, 8'h77, 1'b0);
    pulse(P_DONE);
    serve("R9 eod no crc", 2'd2, 8'h00, 1'b0);
    pulse(P_DONE);
    chk("R9 pending cleared", {31'd0, ifr_pending}, 0);
    // R8 end-of-data cancels retry
    req(1'b0);
    wr(8'h55);
    pulse(P_EODRX);
    serve("R8 byte", 2'd0, 8'h55, 1'b1);
    pulse(P_ARB);
    pulse(P_EODSET);
    chk("R8 eod cancels", {31'd0, ifr_pending}, 0);
    pulse(P_RXB);
    quiet("R8 no retry after eod", 3);
    // R9 end-of-data before start: one attempt
    req(1'b0);
    wr(8'h66);
    pulse(P_EODSET);
    pulse(P_EODRX);
    serve("R9 byte", 2'd0, 8'h66, 1'b1);
    pulse(P_ARB);
    chk("R9 single attempt", {31'd0, ifr_pending}, 0);
    pulse(P_RXB);
    quiet("R9 no retry", 3);

    // R1 start waits for an event; normalization bit starts it; R5 error abort
    req(1'b1);
    wr(8'h99);
    quiet("R1 no event no start", 3);
    pulse(P_NORM);
    serve("R1 norm start", 2'd0, 8'h99, 1'b1);
    pulse(P_RXERR);
    chk("R5 error abort", {31'd0, ifr_pending}, 0);
    quiet("R5 idle after error", 2);
    // R5 idle clears
    req(1'b1);
    wr(8'h88);
    chk("R1 pending set", {31'd0, ifr_pending}, 1);
    pulse(P_OTHER);
    chk("R5 other ifr clears", {31'd0, ifr_pending}, 0);
    pulse(P_EODRX);
    quiet("R5 no start after clear", 3);
    req(1'b1);
    pulse(P_RXERR);
    chk("R5 rx error clears", {31'd0, ifr_pending}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule